// File: doc/BRIEF.md
# DDR2 Write-to-Precharge Spacing Guard

This block sits on the command path of a DDR2-style memory controller and enforces the minimum gap between a write to a bank and a later precharge of that same bank. It watches the command and bank address in every controller clock cycle. For each bank it keeps a down-counter. The counter is loaded when a write, with or without auto-precharge, targets that bank. The gap covers three parts: the write latency (one less than the configured read latency), the data burst (half the burst length, because data moves on both clock edges), and the write recovery time counted in whole clocks.

The scheduler reads the per-bank `pre_allowed` flags before it issues a precharge. The guard also watches the precharges that are actually issued. If a precharge, or a precharge-all, reaches a bank whose spacing has not yet run out, the guard raises a violation flag in the next cycle. The write recovery input is a clock count derived from the analog recovery time. It is independent of the auto-precharge value programmed into the mode register.

Timing configuration is taken live while no bank is counting, and held while any bank is counting. This keeps a burst that is already in flight from being re-timed. The command bus is plain control with no back-pressure: a command counts in the cycle in which it is presented, and `CMD_NOP` means no command.

Top module: `ddr2_wr_pre_guard`

## Requirements
- R1: After reset, every bit of `pre_allowed` is 1 and `pre_violation` is 0.
- R2: A write (`cmd` 3'd3) to bank b presented in cycle 0 clears `pre_allowed[b]` from cycle 1. The flag returns to 1 in cycle S, where S = (RL-1) + BL/2 + tWR. RL is `cfg_rl`, BL is 8 when `cfg_bl8` is 1 and 4 otherwise, and tWR is `cfg_twr`. Supported ranges are RL 3..6 and tWR 2..6.
- R3: A write with auto-precharge (`cmd` 3'd4) starts exactly the same spacing as a plain write.
- R4: A new write to a bank that is still counting restarts its full spacing, measured from the newest write.
- R5: A write to one bank leaves `pre_allowed` of every other bank unchanged.
- R6: A precharge (`cmd` 3'd5) to a bank whose flag is 0 sets `pre_violation` to 1 in the next cycle. A precharge to a bank whose flag is 1 leaves it at 0. The earliest legal precharge is in cycle S.
- R7: A precharge-all (`cmd` 3'd6) sets `pre_violation` in the next cycle if any bank is counting, and leaves it at 0 otherwise.
- R8: The configuration inputs take effect only in cycles where every bank's flag is 1. While any bank is counting, new writes use the configuration that was present in the last such cycle.
- R9: NOP (3'd0), activate (3'd1), read (3'd2) and refresh (3'd7) do not change any bank's spacing and never raise `pre_violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code for this cycle |
| bank | input | 3 | Bank address the command targets |
| cfg_rl | input | 3 | Read latency in clocks |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_twr | input | 3 | Write recovery in clocks |
| pre_allowed | output | 8 | Per-bank flag, 1 when a precharge is legal |
| pre_violation | output | 1 | Registered flag set one cycle after a premature precharge |

## Verification
The spacing is measured over a table of latency, burst and recovery settings. The table spans the minimum and maximum gaps and both burst lengths, so that an error in any single term of the sum changes the measured cycle count. The checks for a premature precharge are placed one cycle before and exactly at the spacing boundary, which catches off-by-one loading of the counter. Other directed sequences cover these cases: a rewrite while a bank is still counting; reads, activates and refreshes sent to a bank that is counting; and a configuration change while a bank is counting. Together they separate spacing measured from the newest write from spacing measured from the first write, and held configuration from live configuration.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_ACT      = 3'd1,
    CMD_READ     = 3'd2,
    CMD_WRITE    = 3'd3,
    CMD_WRITE_AP = 3'd4,
    CMD_PRE      = 3'd5,
    CMD_PRE_ALL  = 3'd6,
    CMD_REF      = 3'd7
  } cmd_e;

  function automatic logic cmd_is_write(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRITE_AP);
  endfunction
endpackage

// File: rtl/ddr2_guard_cfg.sv
module ddr2_guard_cfg #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [2:0]       cfg_rl,
  input  logic             cfg_bl8,
  input  logic [2:0]       cfg_twr,
  output logic [CNT_W-1:0] load_val
);
  logic [2:0] rl_q, twr_q, rl_s, twr_s;
  logic       bl8_q, bl8_s;
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_q  <= 3'd3;
      bl8_q <= 1'b0;
      twr_q <= 3'd2;
    end else if (idle) begin
      rl_q  <= cfg_rl;
      bl8_q <= cfg_bl8;
      twr_q <= cfg_twr;
    end
  end

  always_comb begin
    rl_s  = idle ? cfg_rl  : rl_q;
    bl8_s = idle ? cfg_bl8 : bl8_q;
    twr_s = idle ? cfg_twr : twr_q;
    gap = CNT_W'(rl_s) - CNT_W'(1) + (bl8_s ? CNT_W'(4) : CNT_W'(2)) + CNT_W'(twr_s);
    load_val = gap - CNT_W'(1);
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable({rl_q, bl8_q, twr_q}));
endmodule

// File: rtl/ddr2_guard_bank_timer.sv
module ddr2_guard_bank_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (wr_hit)     cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && busy) |=> (cnt == $past(cnt) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cnt == $past(load_val)));
  assert_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !busy) |=> !busy);
endmodule

// File: rtl/ddr2_guard_viol.sv
module ddr2_guard_viol #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] pre_mask,
  input  logic [NUM_BANKS-1:0] busy,
  output logic                 viol
);
  logic early;
  assign early = |(pre_mask & busy);

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= early;
  end

  assert_flag_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> viol);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_mask == '0) |=> !viol);
endmodule

// File: rtl/ddr2_wr_pre_guard.sv
module ddr2_wr_pre_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic [2:0]           cfg_rl,
  input  logic                 cfg_bl8,
  input  logic [2:0]           cfg_twr,
  output logic [NUM_BANKS-1:0] pre_allowed,
  output logic                 pre_violation
);
  cmd_e                 cmd_q;
  logic [NUM_BANKS-1:0] busy, wr_mask, pre_mask;
  logic [CNT_W-1:0]     load_val;
  logic                 idle;

  assign cmd_q = cmd_e'(cmd);
  assign idle  = ~|busy;

  ddr2_guard_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .cfg_rl(cfg_rl), .cfg_bl8(cfg_bl8), .cfg_twr(cfg_twr),
    .load_val(load_val)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel        = (bank == BA_W'(b));
    assign wr_mask[b] = cmd_is_write(cmd_q) && sel;
    assign pre_mask[b] = (cmd_q == CMD_PRE_ALL) || ((cmd_q == CMD_PRE) && sel);

    ddr2_guard_bank_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_mask[b]),
      .load_val(load_val), .busy(busy[b])
    );
  end

  ddr2_guard_viol #(.NUM_BANKS(NUM_BANKS)) viol_i (
    .clk(clk), .rst_n(rst_n), .pre_mask(pre_mask), .busy(busy),
    .viol(pre_violation)
  );

  assign pre_allowed = ~busy;

  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_mask));
  assert_write_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_is_write(cmd_q)) |=> !pre_allowed[$past(bank)]);
endmodule

// File: tb/ddr2_wr_pre_guard_tb.sv
module ddr2_wr_pre_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [2:0] bank = 3'd0;
  logic [2:0] cfg_rl = 3'd4;
  logic       cfg_bl8 = 1'b0;
  logic [2:0] cfg_twr = 3'd3;
  logic [7:0] pre_allowed;
  logic       pre_violation;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ddr2_wr_pre_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .cfg_rl(cfg_rl), .cfg_bl8(cfg_bl8), .cfg_twr(cfg_twr),
    .pre_allowed(pre_allowed), .pre_violation(pre_violation)
  );

  // {rl[11:9], bl8[8], twr[7:5], expected spacing[4:0]}
  localparam logic [11:0] VECS [0:5] = '{
    {3'd4, 1'b0, 3'd3, 5'd8},
    {3'd5, 1'b0, 3'd3, 5'd9},
    {3'd3, 1'b0, 3'd2, 5'd6},
    {3'd6, 1'b1, 3'd6, 5'd15},
    {3'd3, 1'b1, 3'd4, 5'd10},
    {3'd6, 1'b0, 3'd2, 5'd9}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [2:0] b);
    cmd  = c;
    bank = b;
  endtask

  // counts cycles until pre_allowed[b] is 1; start = cycle index already reached
  task automatic count_to_ok(logic [2:0] b, int start, output int n);
    n = start;
    while (!pre_allowed[b] && n < 40) begin
      tick();
      n++;
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && pre_allowed != 8'hFF; k++) tick();
    tick();
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 pre_allowed after reset", pre_allowed, 8'hFF);
    check("R1 pre_violation after reset", pre_violation, 0);

    // table walk: R2 spacing, R3 auto-precharge write gives same gap
    for (int i = 0; i < 6; i++) begin
      logic [2:0] b;
      b = 3'((i * 3) % 8);
      cfg_rl  = VECS[i][11:9];
      cfg_bl8 = VECS[i][8];
      cfg_twr = VECS[i][7:5];
      issue((i % 2 == 1) ? 3'd4 : 3'd3, b);
      tick();
      issue(3'd0, 3'd0);
      check("R2 flag cleared after write", pre_allowed[b], 0);
      count_to_ok(b, 1, n);
      check((i % 2 == 1) ? "R3 spacing write-ap" : "R2 spacing write", n, int'(VECS[i][4:0]));
      wait_idle();
    end

    cfg_rl = 3'd4; cfg_bl8 = 1'b0; cfg_twr = 3'd3; // S = 8

    // R6: precharge at cycle 7 is early, at cycle 8 is legal
    issue(3'd3, 3'd2);
    tick();
    issue(3'd0, 3'd0);
    repeat (6) tick();
    issue(3'd5, 3'd2);
    tick();
    check("R6 early precharge flagged", pre_violation, 1);
    check("R6 allowed at cycle S", pre_allowed[2], 1);
    tick();
    issue(3'd0, 3'd0);
    check("R6 precharge at cycle S not flagged", pre_violation, 0);
    wait_idle();

    // R7: precharge-all while bank5 busy; then single pre to idle bank
    issue(3'd3, 3'd5);
    tick();
    issue(3'd6, 3'd0);
    tick();
    check("R7 precharge-all with busy bank", pre_violation, 1);
    issue(3'd5, 3'd0);
    tick();
    issue(3'd0, 3'd0);
    check("R6 precharge to idle bank", pre_violation, 0);
    check("R5 idle bank unaffected", pre_allowed[0], 1);
    wait_idle();
    issue(3'd6, 3'd0);
    tick();
    issue(3'd0, 3'd0);
    check("R7 precharge-all when idle", pre_violation, 0);

    // R4: rewrite at cycle 4 restarts spacing
    issue(3'd3, 3'd1);
    tick();
    issue(3'd0, 3'd0);
    repeat (3) tick();
    issue(3'd4, 3'd1);
    tick();
    issue(3'd0, 3'd0);
    count_to_ok(3'd1, 1, n);
    check("R4 spacing from newest write", n, 8);
    wait_idle();

    // R5 / R9: other banks untouched; read/act/ref do not disturb
    issue(3'd3, 3'd3);
    tick();
    check("R5 neighbour bank stays allowed", pre_allowed[4], 1);
    check("R5 written bank blocked", pre_allowed[3], 0);
    v = 0;
    issue(3'd2, 3'd3); tick(); v += pre_violation;
    issue(3'd1, 3'd3); tick(); v += pre_violation;
    issue(3'd7, 3'd3); tick(); v += pre_violation;
    issue(3'd0, 3'd3); tick(); v += pre_violation;
    check("R9 no violation from other commands", v, 0);
    count_to_ok(3'd3, 5, n);
    check("R9 spacing unchanged by other commands", n, 8);
    wait_idle();

    // R8: configuration change while busy is held
    issue(3'd3, 3'd0);
    tick();
    cfg_rl = 3'd6; cfg_bl8 = 1'b1; cfg_twr = 3'd6; // S = 15 once applied
    issue(3'd3, 3'd6);
    tick();
    issue(3'd0, 3'd0);
    count_to_ok(3'd6, 1, n);
    check("R8 held config while busy", n, 8);
    wait_idle();
    issue(3'd3, 3'd7);
    tick();
    issue(3'd0, 3'd0);
    count_to_ok(3'd7, 1, n);
    check("R8 new config after idle", n, 15);
    wait_idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule